// File: doc/BRIEF.md
# Shared interrupt source router

The router takes a parameterised set of external level-sensitive interrupt sources and steers each one to a single CPU interrupt line on a single core. Every source has its own state: an enable bit, a pending bit, a pin selection and a core selection. Each core has a bank of interrupt output lines. A line is high when at least one source is enabled, pending and steered to that core and pin, or when the core's local compare (timer) request for that pin is active.

Software controls the block through a word-addressed register port. One write port and one combinational read port are provided. Enables are changed only through dedicated set and clear words. Pending bits follow the input levels, and software can force them through a single edge-injection word. The core selection is written as a one-hot bitmap, and the design turns it into an index. The source count must be a nonzero multiple of 8 and at most 256. Any other value stops elaboration.

Top module: `irq_src_router`

## Requirements
- R1: After reset, every source reads as disabled and not pending. Every pin-map word reads 0x8000_0000 (only the map-to-pin flag set). Every core-map word reads 0. All outputs are low.
- R2: A write to word 0x010+w sets the enable of source 32w+j for each data bit j that is 1. Bits written as 0 leave their enables unchanged.
- R3: A write to word 0x018+w clears the enable of source 32w+j for each data bit j that is 1. Bits written as 0 leave their enables unchanged.
- R4: Word 0x000+w reads pending and word 0x008+w reads enable, with one bit per source: bit j is source 32w+j. Bits and words for sources that do not exist read 0.
- R5: A change on a source input sets that source's pending bit to the new level, whether or not the source is enabled.
- R6: A write to word 0x020 is an edge injection. Data[30:0] is the source number and data[31] is the value put in its pending bit. A source number of NUM_SRC or above changes nothing. An input change on the same source in the same cycle wins over the injection.
- R7: Pin-map word 0x100+s holds the pin number in bits [5:0] and the map-to-pin flag in bit 31. It reads back as {flag, 25'b0, pin}. A write whose pin field is NUM_PIN or above is ignored.
- R8: Core-map word 0x200+s takes a bitmap. The lowest set bit selects the core. An all-zero write unmaps the source. A write whose lowest set bit is NUM_CORE or above is ignored. A read returns 1 shifted left by the core index, or 0 when the source is unmapped.
- R9: Output bit core_irq[c*LINE_W + PIN_OFS + p] is the OR of all sources that are enabled, pending, mapped to core c and on pin p, together with tmr_req[c*NUM_PIN + p]. The PIN_OFS low bits of each core's group stay 0.
- R10: On a line shared by several contributors, the line stays high until every contributing source and the timer request on that line are inactive.
- R11: The outputs are registered. They change on the first clock edge after an input change or a register write, and never within the same cycle.
- R12: A disabled source or a source mapped to no core never drives any output.
- R13: Pin-map and core-map words for source numbers of NUM_SRC or above read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl | input | NUM_SRC | External interrupt source levels |
| tmr_req | input | NUM_CORE*NUM_PIN | Local compare requests, already decoded per core and pin |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 10 | Register write word address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 10 | Register read word address |
| rd_data | output | 32 | Register read data (combinational) |
| core_irq | output | NUM_CORE*(NUM_PIN+PIN_OFS) | Per-core CPU interrupt lines |

## Verification
A source input can change on the same clock edge as an edge-injection write that targets that source. When this happens, the input level must decide the pending bit. The bench provokes the clash twice from a single negative clock edge. The first time, it raises the input while injecting a deassert. The second time, it drops the input while injecting an assert. In both cases it checks the pending read word and the routed output line against the input level. A second overlap arises when a timer request and a routed source share a line. The bench drops each contributor in turn and expects the line to stay high until the last one is gone.

// File: rtl/irq_src_router_pkg.sv
package irq_src_router_pkg;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int PF_W   = 6;   // pin field width in the pin-map word
  localparam int CI_W   = 5;   // core index width (up to 32 cores)

  // word addresses
  localparam logic [ADDR_W-1:0] A_PEND  = 10'h000;
  localparam logic [ADDR_W-1:0] A_EN    = 10'h008;
  localparam logic [ADDR_W-1:0] A_SET   = 10'h010;
  localparam logic [ADDR_W-1:0] A_CLR   = 10'h018;
  localparam logic [ADDR_W-1:0] A_WEDGE = 10'h020;
  localparam logic [ADDR_W-1:0] A_PMAP  = 10'h100;
  localparam logic [ADDR_W-1:0] A_CMAP  = 10'h200;

  typedef struct packed {
    logic            en;
    logic            pend;
    logic            flag;
    logic [PF_W-1:0] pin;
    logic            cvld;
    logic [CI_W-1:0] cidx;
  } src_st_t;

  localparam src_st_t SRC_RST = '{en: 1'b0, pend: 1'b0, flag: 1'b1,
                                  pin: '0, cvld: 1'b0, cidx: '0};

  // index of the lowest set bit; only meaningful when v is nonzero
  function automatic logic [CI_W-1:0] first_one(input logic [DATA_W-1:0] v);
    logic [CI_W-1:0] r;
    r = '0;
    for (int b = DATA_W - 1; b >= 0; b--)
      if (v[b]) r = CI_W'(b);
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pmap_word(input src_st_t s);
    return {s.flag, {(DATA_W-1-PF_W){1'b0}}, s.pin};
  endfunction

  function automatic logic [DATA_W-1:0] cmap_word(input src_st_t s);
    return s.cvld ? (DATA_W'(1) << s.cidx) : '0;
  endfunction

  // does this source drive core c, pin p
  function automatic logic routes_to(input src_st_t s, input int c, input int p);
    return s.en && s.pend && s.cvld && (int'(s.cidx) == c) && (int'(s.pin) == p);
  endfunction

endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell
  import irq_src_router_pkg::*;
#(
  parameter int IDX      = 0,
  parameter int NUM_PIN  = 6,
  parameter int NUM_CORE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              src_lvl_i,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output src_st_t           st_q,
  output src_st_t           st_n,
  output logic              chg
);

  localparam logic [ADDR_W-1:0] WORD = ADDR_W'(IDX / 32);
  localparam int                BITP = IDX % 32;

  logic src_q;
  logic set_hit, clr_hit, wedge_hit, pmap_hit, cmap_hit;
  logic [CI_W-1:0] lowest;

  assign chg       = src_lvl_i != src_q;
  assign set_hit   = wr_en && (wr_addr == A_SET + WORD) && wr_data[BITP];
  assign clr_hit   = wr_en && (wr_addr == A_CLR + WORD) && wr_data[BITP];
  assign wedge_hit = wr_en && (wr_addr == A_WEDGE) && (wr_data[30:0] == 31'(IDX));
  assign pmap_hit  = wr_en && (wr_addr == A_PMAP + ADDR_W'(IDX));
  assign cmap_hit  = wr_en && (wr_addr == A_CMAP + ADDR_W'(IDX));
  assign lowest    = first_one(wr_data);

  always_comb begin
    st_n = st_q;
    if (set_hit) st_n.en = 1'b1;
    if (clr_hit) st_n.en = 1'b0;
    // input change outranks a same-cycle injection
    if (chg)            st_n.pend = src_lvl_i;
    else if (wedge_hit) st_n.pend = wr_data[31];
    if (pmap_hit && (int'(wr_data[PF_W-1:0]) < NUM_PIN)) begin
      st_n.flag = wr_data[31];
      st_n.pin  = wr_data[PF_W-1:0];
    end
    if (cmap_hit) begin
      if (wr_data == '0) begin
        st_n.cvld = 1'b0;
      end else if (int'(lowest) < NUM_CORE) begin
        st_n.cvld = 1'b1;
        st_n.cidx = lowest;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= SRC_RST;
      src_q <= 1'b0;
    end else begin
      st_q  <= st_n;
      src_q <= src_lvl_i;
    end
  end

endmodule

// File: rtl/irq_route.sv
module irq_route
  import irq_src_router_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2,
  parameter int NUM_PIN  = 6,
  parameter int PIN_OFS  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  src_st_t                     st_n [NUM_SRC],
  input  logic [NUM_CORE*NUM_PIN-1:0] tmr_req,
  output logic [NUM_CORE*(NUM_PIN+PIN_OFS)-1:0] core_irq
);

  localparam int LINE_W = NUM_PIN + PIN_OFS;

  logic [NUM_CORE*LINE_W-1:0] hit_vec;

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
    if (PIN_OFS > 0) begin : g_low
      assign hit_vec[c*LINE_W +: PIN_OFS] = '0;
    end
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
      logic hit;
      always_comb begin
        hit = tmr_req[c*NUM_PIN + p];
        for (int i = 0; i < NUM_SRC; i++)
          if (routes_to(st_n[i], c, p)) hit = 1'b1;
      end
      assign hit_vec[c*LINE_W + PIN_OFS + p] = hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) core_irq <= '0;
    else        core_irq <= hit_vec;
  end

endmodule

// File: rtl/irq_src_router.sv
module irq_src_router
  import irq_src_router_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2,
  parameter int NUM_PIN  = 6,
  parameter int PIN_OFS  = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_SRC-1:0]          src_lvl,
  input  logic [NUM_CORE*NUM_PIN-1:0] tmr_req,
  input  logic                        wr_en,
  input  logic [9:0]                  wr_addr,
  input  logic [31:0]                 wr_data,
  input  logic [9:0]                  rd_addr,
  output logic [31:0]                 rd_data,
  output logic [NUM_CORE*(NUM_PIN+PIN_OFS)-1:0] core_irq
);

  localparam int NWORD = (NUM_SRC + 31) / 32;

  if ((NUM_SRC == 0) || (NUM_SRC % 8 != 0) || (NUM_SRC > 256)) begin : g_bad_src
    $error("NUM_SRC must be a nonzero multiple of 8, at most 256");
  end
  if ((NUM_CORE < 1) || (NUM_CORE > 32) || (NUM_PIN < 1) || (NUM_PIN > 63)) begin : g_bad_cfg
    $error("NUM_CORE must be 1..32 and NUM_PIN 1..63");
  end

  src_st_t st_q [NUM_SRC];
  src_st_t st_n [NUM_SRC];

  // named views for the checker
  logic [NUM_SRC-1:0]      pend_vec, en_vec, chg_vec;
  logic [NUM_SRC*PF_W-1:0] pin_flat;
  logic                    set_wr, pmap_rej;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    irq_src_cell #(.IDX(i), .NUM_PIN(NUM_PIN), .NUM_CORE(NUM_CORE)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_lvl_i (src_lvl[i]),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .st_q      (st_q[i]),
      .st_n      (st_n[i]),
      .chg       (chg_vec[i])
    );
    assign pend_vec[i]             = st_q[i].pend;
    assign en_vec[i]               = st_q[i].en;
    assign pin_flat[i*PF_W +: PF_W] = st_q[i].pin;
  end

  assign set_wr   = wr_en && (wr_addr >= A_SET) && (wr_addr < A_SET + ADDR_W'(NWORD));
  assign pmap_rej = wr_en && (wr_addr >= A_PMAP) && (wr_addr < A_PMAP + ADDR_W'(NUM_SRC))
                    && (int'(wr_data[PF_W-1:0]) >= NUM_PIN);

  irq_route #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN),
              .PIN_OFS(PIN_OFS)) u_route (
    .clk      (clk),
    .rst_n    (rst_n),
    .st_n     (st_n),
    .tmr_req  (tmr_req),
    .core_irq (core_irq)
  );

  logic [NWORD*32-1:0] pend_pad, en_pad;

  always_comb begin
    pend_pad = '0;
    en_pad   = '0;
    pend_pad[NUM_SRC-1:0] = pend_vec;
    en_pad[NUM_SRC-1:0]   = en_vec;
  end

  always_comb begin
    rd_data = '0;
    for (int w = 0; w < NWORD; w++) begin
      if (rd_addr == A_PEND + ADDR_W'(w)) rd_data = pend_pad[w*32 +: 32];
      if (rd_addr == A_EN + ADDR_W'(w))   rd_data = en_pad[w*32 +: 32];
    end
    for (int i = 0; i < NUM_SRC; i++) begin
      if (rd_addr == A_PMAP + ADDR_W'(i)) rd_data = pmap_word(st_q[i]);
      if (rd_addr == A_CMAP + ADDR_W'(i)) rd_data = cmap_word(st_q[i]);
    end
  end

endmodule

// File: rtl/irq_src_router_chk.sv
module irq_src_router_chk
  import irq_src_router_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_CORE = 2,
  parameter int NUM_PIN  = 6,
  parameter int PIN_OFS  = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_SRC-1:0]          src_lvl,
  input logic [NUM_CORE*NUM_PIN-1:0] tmr_req,
  input logic                        wr_en,
  input logic [9:0]                  wr_addr,
  input logic [31:0]                 wr_data,
  input logic [NUM_CORE*(NUM_PIN+PIN_OFS)-1:0] core_irq,
  input logic [NUM_SRC-1:0]          pend_vec,
  input logic [NUM_SRC-1:0]          en_vec,
  input logic [NUM_SRC-1:0]          chg_vec,
  input logic [NUM_SRC*PF_W-1:0]     pin_flat,
  input logic                        set_wr,
  input logic                        pmap_rej
);

  localparam int LINE_W = NUM_PIN + PIN_OFS;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    // R5
    pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_vec[i] |=> (pend_vec[i] == $past(src_lvl[i])));
  end

  for (genvar c = 0; c < NUM_CORE; c++) begin : g_c
    for (genvar p = 0; p < NUM_PIN; p++) begin : g_p
      // R9
      tmr_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_req[c*NUM_PIN + p] |=> core_irq[c*LINE_W + PIN_OFS + p]);
    end
  end

  // R7
  pmap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pmap_rej |=> $stable(pin_flat));

  // R12
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((en_vec == '0) && !set_wr && (tmr_req == '0)) |=> (core_irq == '0));

  // R6
  wedge_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == A_WEDGE) && (int'(wr_data[30:0]) >= NUM_SRC) && (chg_vec == '0))
    |=> $stable(pend_vec));

endmodule

bind irq_src_router irq_src_router_chk #(
  .NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN), .PIN_OFS(PIN_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .tmr_req(tmr_req),
  .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .core_irq(core_irq),
  .pend_vec(pend_vec), .en_vec(en_vec), .chg_vec(chg_vec),
  .pin_flat(pin_flat), .set_wr(set_wr), .pmap_rej(pmap_rej)
);

// File: tb/irq_src_router_bench.sv
module irq_src_router_bench;

  localparam int PERIOD   = 10;
  localparam int NUM_SRC  = 16;
  localparam int NUM_CORE = 2;
  localparam int NUM_PIN  = 6;
  localparam int PIN_OFS  = 2;
  localparam int LINE_W   = NUM_PIN + PIN_OFS;
  localparam int WD_CYC   = 20000;

  logic                        clk = 1'b0;
  logic                        rst_n = 1'b0;
  logic [NUM_SRC-1:0]          src_lvl = '0;
  logic [NUM_CORE*NUM_PIN-1:0] tmr_req = '0;
  logic                        wr_en = 1'b0;
  logic [9:0]                  wr_addr = '0;
  logic [31:0]                 wr_data = '0;
  logic [9:0]                  rd_addr = '0;
  logic [31:0]                 rd_data;
  logic [NUM_CORE*LINE_W-1:0]  core_irq;

  int n_chk = 0;
  int n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  irq_src_router #(.NUM_SRC(NUM_SRC), .NUM_CORE(NUM_CORE), .NUM_PIN(NUM_PIN),
                   .PIN_OFS(PIN_OFS)) u_irq_src_router (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .tmr_req(tmr_req),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .core_irq(core_irq)
  );

  // op: 0 write, 1 read check, 2 drive sources, 3 output check
  // fields: op[79:78] req[77:74] addr[73:64] data[63:32] expected[31:0]
  localparam int N = 46;
  localparam logic [79:0] TBL [N] = '{
    {2'd1, 4'd1,  10'h100, 32'h0,         32'h8000_0000}, // R1 pin map reset
    {2'd1, 4'd1,  10'h200, 32'h0,         32'h0},         // R1 core map reset
    {2'd1, 4'd1,  10'h008, 32'h0,         32'h0},         // R1 enables reset
    {2'd3, 4'd1,  10'h000, 32'h0,         32'h0},         // R1 outputs low
    {2'd0, 4'd7,  10'h100, 32'h8000_0003, 32'h0},         // R7 src0 -> pin 3
    {2'd1, 4'd7,  10'h100, 32'h0,         32'h8000_0003},
    {2'd0, 4'd7,  10'h100, 32'h0000_0006, 32'h0},         // R7 pin 6 rejected
    {2'd1, 4'd7,  10'h100, 32'h0,         32'h8000_0003},
    {2'd0, 4'd8,  10'h200, 32'h0000_0006, 32'h0},         // R8 lowest bit -> core 1
    {2'd1, 4'd8,  10'h200, 32'h0,         32'h2},
    {2'd0, 4'd8,  10'h200, 32'h0000_0004, 32'h0},         // R8 core 2 rejected
    {2'd1, 4'd8,  10'h200, 32'h0,         32'h2},
    {2'd2, 4'd5,  10'h000, 32'h0000_0001, 32'h0},         // R5 disabled src0 rises
    {2'd1, 4'd5,  10'h000, 32'h0,         32'h1},
    {2'd3, 4'd12, 10'h000, 32'h0,         32'h0},         // R12 disabled: no output
    {2'd0, 4'd2,  10'h010, 32'h0000_0001, 32'h0},         // R2 enable src0
    {2'd1, 4'd2,  10'h008, 32'h0,         32'h1},
    {2'd3, 4'd9,  10'h000, 32'h0,         32'h2000},      // R9 core1 line 5
    {2'd0, 4'd7,  10'h101, 32'h0000_0003, 32'h0},
    {2'd0, 4'd8,  10'h201, 32'h0000_0002, 32'h0},
    {2'd0, 4'd2,  10'h010, 32'h0000_0002, 32'h0},         // R2 zero bits keep src0
    {2'd1, 4'd2,  10'h008, 32'h0,         32'h3},
    {2'd0, 4'd6,  10'h020, 32'h8000_0001, 32'h0},         // R6 inject src1
    {2'd1, 4'd6,  10'h000, 32'h0,         32'h3},
    {2'd2, 4'd10, 10'h000, 32'h0,         32'h0},         // R10 src0 drops
    {2'd1, 4'd5,  10'h000, 32'h0,         32'h2},
    {2'd3, 4'd10, 10'h000, 32'h0,         32'h2000},      // R10 src1 keeps line
    {2'd0, 4'd10, 10'h020, 32'h0000_0001, 32'h0},
    {2'd3, 4'd10, 10'h000, 32'h0,         32'h0},         // R10 last one gone
    {2'd0, 4'd6,  10'h020, 32'h8000_0010, 32'h0},         // R6 source 16 ignored
    {2'd1, 4'd6,  10'h000, 32'h0,         32'h0},
    {2'd0, 4'd3,  10'h018, 32'h0000_0001, 32'h0},         // R3 clear src0
    {2'd1, 4'd3,  10'h008, 32'h0,         32'h2},
    {2'd1, 4'd13, 10'h110, 32'h0,         32'h0},         // R13 no such source
    {2'd1, 4'd13, 10'h210, 32'h0,         32'h0},
    {2'd0, 4'd13, 10'h110, 32'h0000_0001, 32'h0},
    {2'd1, 4'd13, 10'h100, 32'h0,         32'h8000_0003},
    {2'd2, 4'd4,  10'h000, 32'h0000_FFFF, 32'h0},         // R4 all pending
    {2'd1, 4'd4,  10'h000, 32'h0,         32'h0000_FFFF},
    {2'd1, 4'd4,  10'h001, 32'h0,         32'h0},
    {2'd3, 4'd9,  10'h000, 32'h0,         32'h2000},
    {2'd0, 4'd8,  10'h201, 32'h0,         32'h0},         // R8 unmap src1
    {2'd1, 4'd8,  10'h201, 32'h0,         32'h0},
    {2'd3, 4'd12, 10'h000, 32'h0,         32'h0},         // R12 unmapped: no output
    {2'd2, 4'd5,  10'h000, 32'h0,         32'h0},
    {2'd1, 4'd5,  10'h000, 32'h0,         32'h0}
  };

  task automatic chk(input int rq, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", rq, got, exp);
    end
  endtask

  task automatic do_wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input int rq, input logic [9:0] a, input logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(rq, rd_data, exp);
  endtask

  task automatic irq_chk(input int rq, input logic [31:0] exp);
    chk(rq, 32'(core_irq), exp);
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung run, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < N; k++) begin
      logic [1:0]  op;
      int          rq;
      logic [9:0]  ad;
      logic [31:0] dt, ex;
      op = TBL[k][79:78];
      rq = int'(TBL[k][77:74]);
      ad = TBL[k][73:64];
      dt = TBL[k][63:32];
      ex = TBL[k][31:0];
      case (op)
        2'd0: do_wr(ad, dt);
        2'd1: rd_chk(rq, ad, ex);
        2'd2: begin
          @(negedge clk);
          src_lvl = dt[NUM_SRC-1:0];
          @(negedge clk);
        end
        default: irq_chk(rq, ex);
      endcase
    end

    // R11: timer request core0 pin0 -> line 2, visible only after an edge
    @(negedge clk);
    tmr_req = 12'h001;
    #1;
    irq_chk(11, 32'h0);                  // R11 not combinational
    @(negedge clk);
    irq_chk(9, 32'h0004);                // R9 timer contributes
    tmr_req = '0;
    @(negedge clk);
    irq_chk(11, 32'h0);

    // R6: same-cycle input change and injection on source 2 (core0 pin1)
    do_wr(10'h102, 32'h1);
    do_wr(10'h202, 32'h1);
    do_wr(10'h010, 32'h4);
    @(negedge clk);
    src_lvl = 16'h0004;
    wr_en = 1'b1; wr_addr = 10'h020; wr_data = 32'h0000_0002;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk(6, 10'h000, 32'h4);           // R6 input wins over deassert
    irq_chk(6, 32'h0008);
    src_lvl = 16'h0000;
    wr_en = 1'b1; wr_addr = 10'h020; wr_data = 32'h8000_0002;
    @(negedge clk);
    wr_en = 1'b0;
    rd_chk(6, 10'h000, 32'h0);           // R6 input wins over assert
    irq_chk(6, 32'h0);

    // R10: source and timer share core0 line 3
    src_lvl = 16'h0004;
    @(negedge clk);
    irq_chk(10, 32'h0008);
    tmr_req = 12'h002;
    @(negedge clk);
    src_lvl = 16'h0000;
    @(negedge clk);
    irq_chk(10, 32'h0008);               // R10 timer still holds the line
    tmr_req = '0;
    @(negedge clk);
    irq_chk(10, 32'h0);

    // R1: reset in mid-run
    do_wr(10'h100, 32'h0000_0004);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd_chk(1, 10'h008, 32'h0);
    rd_chk(1, 10'h100, 32'h8000_0000);
    rd_chk(1, 10'h202, 32'h0);
    rd_chk(1, 10'h000, 32'h0);
    irq_chk(1, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule